// File: doc/BRIEF.md
# Firmware Memory Read Target for a Low Pin Count Bus

This block is the target side of a narrow multiplexed host bus. Each host transaction passes over a 4-bit bidirectional nibble path (split here into `ladIn`, `ladOut` and `ladOe`), framed by an active-low strobe. The target watches for the code that opens a firmware memory read and checks a select nibble against four strap pins. It then assembles a 28-bit address from seven nibbles sent most-significant first. After the address it checks that the size nibble asks for one byte.

After the address, the target issues a single read on a synchronous memory port and registers the returned byte. It waits out the bus turnaround, then drives a ready sync nibble, the byte as two nibbles with the low nibble first, and a closing all-ones nibble before it releases the bus. Asserting the strobe at any point aborts the transaction in progress and starts start-code detection again.

Top module: `lpc_fw_read_target`

## Requirements
- R1: While `rstN` is low, `ladOe` and `memRdEn` are 0.
- R2: A transaction opens only when the nibble 1101b is sampled with `frameN` low. Any other opening nibble leaves `ladOe` and `memRdEn` at 0 for the rest of that transaction.
- R3: While `frameN` stays low for several clocks, only the nibble sampled on the last low clock is taken as the opening code.
- R4: The nibble after the opening code must equal `idStrap`. On a mismatch the target never asserts `ladOe` or `memRdEn` before the next frame.
- R5: The seven nibbles after the select form the address, first nibble as bits 27:24 and last as bits 3:0. `memRdEn` is high for exactly one clock, the clock in which the size nibble is on the bus, with `memAddr` holding that address. The memory returns `memRdData` one clock after `memRdEn`.
- R6: A size nibble other than 0000b leaves `ladOe` low for the rest of the transaction.
- R7: In the clock after the size nibble the target leaves the bus floating. In the next clock it drives 1111b.
- R8: The target then drives the ready sync value 0000b for exactly one clock.
- R9: The two clocks after the sync carry the read byte, bits 3:0 first and then bits 7:4.
- R10: After the byte the target drives 1111b for one clock, then deasserts `ladOe`.
- R11: A low `frameN` in any state aborts the transaction: `ladOe` is low from the next clock, and a following opening code starts a new transaction normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields are sampled and launched on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Active-low frame strobe from the host |
| ladIn | input | 4 | Nibble sampled from the shared bus |
| ladOut | output | 4 | Nibble the target drives |
| ladOe | output | 1 | High while the target owns the bus |
| idStrap | input | 4 | Strapped device select value |
| memRdEn | output | 1 | One-clock read request to the memory |
| memAddr | output | 28 | Address captured from the bus |
| memRdData | input | 8 | Byte returned by the memory one clock after the request |

## Verification
The bench looks for the start-code rule under a long strobe, where using the first low nibble instead of the last would answer a transaction that was never opened or ignore one that was. It sends select and size mismatches. A design that let either through would drive the bus against another target, or would float the bus while the host expects data. It aborts transactions both during the address and during the sync nibble, where a design that kept driving would collide with the host. Distinct addresses and bytes expose swapped nibble order in either direction, a request that fires twice, and an output shifted by one clock in the turnaround.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  localparam logic [3:0] START_FW_READ = 4'b1101;
  localparam logic [3:0] SIZE_ONE_BYTE = 4'b0000;
  localparam logic [3:0] SYNC_READY    = 4'b0000;
  localparam logic [3:0] NIB_ONES      = 4'b1111;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IDSEL,
    ST_ADDR,
    ST_SIZE,
    ST_TAR0,
    ST_TAR1,
    ST_SYNC,
    ST_DLO,
    ST_DHI,
    ST_TEND
  } cycState_e;

  typedef enum logic [1:0] {
    OUT_ONES,
    OUT_SYNC,
    OUT_LO,
    OUT_HI
  } outSel_e;

  typedef struct packed {
    logic    addrShift;
    logic    dataCapture;
    logic    drive;
    outSel_e sel;
  } dpStrobe_t;

endpackage

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic [3:0] ladIn,
  input  logic [3:0] idStrap,
  output logic       memRdEn,
  output dpStrobe_t  strobe
);

  localparam int NIB   = ADDR_W / 4;
  localparam int CNT_W = (NIB > 1) ? $clog2(NIB) : 1;
  localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(NIB - 1);

  cycState_e        state;
  logic [CNT_W-1:0] nibCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      nibCnt <= '0;
    end else if (!frameN) begin
      state  <= (ladIn == START_FW_READ) ? ST_IDSEL : ST_IDLE;
      nibCnt <= '0;
    end else begin
      case (state)
        ST_IDLE:  state <= ST_IDLE;
        ST_IDSEL: begin
          state  <= (ladIn == idStrap) ? ST_ADDR : ST_IDLE;
          nibCnt <= '0;
        end
        ST_ADDR: begin
          if (nibCnt == LAST_NIB) state <= ST_SIZE;
          else                    nibCnt <= nibCnt + 1'b1;
        end
        ST_SIZE:  state <= (ladIn == SIZE_ONE_BYTE) ? ST_TAR0 : ST_IDLE;
        ST_TAR0:  state <= ST_TAR1;
        ST_TAR1:  state <= ST_SYNC;
        ST_SYNC:  state <= ST_DLO;
        ST_DLO:   state <= ST_DHI;
        ST_DHI:   state <= ST_TEND;
        ST_TEND:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.addrShift   = frameN && (state == ST_ADDR);
    strobe.dataCapture = (state == ST_TAR0);
    strobe.drive       = 1'b0;
    strobe.sel         = OUT_ONES;
    case (state)
      ST_TAR1: begin strobe.drive = 1'b1; strobe.sel = OUT_ONES; end
      ST_SYNC: begin strobe.drive = 1'b1; strobe.sel = OUT_SYNC; end
      ST_DLO:  begin strobe.drive = 1'b1; strobe.sel = OUT_LO;   end
      ST_DHI:  begin strobe.drive = 1'b1; strobe.sel = OUT_HI;   end
      ST_TEND: begin strobe.drive = 1'b1; strobe.sel = OUT_ONES; end
      default: begin strobe.drive = 1'b0; strobe.sel = OUT_ONES; end
    endcase
    memRdEn = (state == ST_SIZE);
  end

  // R5
  mem_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R7
  tar_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.drive) |-> $past(memRdEn, 2));

  // R11
  abort_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> !strobe.drive);

endmodule

// File: rtl/lpc_dpath.sv
module lpc_dpath
  import lpc_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        ladIn,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] addrReg,
  output logic [3:0]        ladOut,
  output logic              ladOe
);

  logic [7:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.addrShift)   addrReg <= {addrReg[ADDR_W-5:0], ladIn};
      if (strobe.dataCapture) dataReg <= memRdData;
    end
  end

  always_comb begin
    case (strobe.sel)
      OUT_SYNC: ladOut = SYNC_READY;
      OUT_LO:   ladOut = dataReg[3:0];
      OUT_HI:   ladOut = dataReg[7:4];
      default:  ladOut = NIB_ONES;
    endcase
    ladOe = strobe.drive;
  end

  // R8
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ladOe && $past(ladOe) && !$past(ladOe, 2)) |-> (ladOut == SYNC_READY));

  // R10
  tail_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ladOe) && $past(frameN)) |-> ($past(ladOut) == NIB_ONES));

endmodule

// File: rtl/lpc_fw_read_target.sv
module lpc_fw_read_target
  import lpc_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        ladIn,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  input  logic [3:0]        idStrap,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData
);

  dpStrobe_t strobe;

  lpc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .ladIn   (ladIn),
    .idStrap (idStrap),
    .memRdEn (memRdEn),
    .strobe  (strobe)
  );

  lpc_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .frameN    (frameN),
    .ladIn     (ladIn),
    .strobe    (strobe),
    .memRdData (memRdData),
    .addrReg   (memAddr),
    .ladOut    (ladOut),
    .ladOe     (ladOe)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!ladOe && !memRdEn));

endmodule

// File: tb/tb_lpc_fw_read_target.sv
module tb_lpc_fw_read_target;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic [3:0]  ladIn = 4'hF;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic [3:0]  idStrap = 4'hA;
  logic        memRdEn;
  logic [27:0] memAddr;
  logic [7:0]  memRdData = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpc_fw_read_target dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .ladIn(ladIn),
    .ladOut(ladOut), .ladOe(ladOe), .idStrap(idStrap),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData)
  );

  function automatic logic [7:0] memByte(input logic [27:0] a);
    return a[7:0] ^ a[27:20] ^ 8'h5C;
  endfunction

  // bench-side memory: one clock of read latency
  always @(posedge clk) if (memRdEn) memRdData <= memByte(memAddr);

  // check this clock's outputs against the model, then drive next inputs
  task automatic step(input logic f, input logic [3:0] n, input logic eOe,
                      input logic [3:0] eVal, input logic eRd,
                      input logic [27:0] eAddr, input string req);
    @(negedge clk);
    checks++;
    if (ladOe !== eOe || (eOe && ladOut !== eVal)) begin
      errors++;
      $display("FAIL %s bus: oe=%0b val=%h expected oe=%0b val=%h",
               req, ladOe, ladOut, eOe, eVal);
    end
    checks++;
    if (memRdEn !== eRd || (eRd && memAddr !== eAddr)) begin
      errors++;
      $display("FAIL %s mem: rd=%0b addr=%h expected rd=%0b addr=%h",
               req, memRdEn, memAddr, eRd, eAddr);
    end
    frameN = f;
    ladIn  = n;
  endtask

  task automatic openNib(input logic [3:0] n, input string req);
    step(1'b0, n, 1'b0, 4'h0, 1'b0, '0, req);
  endtask

  // rest of a transaction after the opening nibble(s)
  task automatic body(input bit armed, input logic [3:0] idNib,
                      input logic [27:0] addr, input logic [3:0] sz,
                      input bit abortSync);
    bit hit;
    bit go;
    logic [7:0] d;
    hit = armed && (idNib == idStrap);
    go  = hit && (sz == 4'h0);
    d   = memByte(addr);
    step(1'b1, idNib, 1'b0, 4'h0, 1'b0, '0, "R2");
    for (int i = 6; i >= 0; i--)
      step(1'b1, addr[i*4 +: 4], 1'b0, 4'h0, 1'b0, '0, "R4");
    step(1'b1, sz, 1'b0, 4'h0, hit, addr, "R5");
    step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, '0, "R7");
    if (go) begin
      step(1'b1, 4'hF, 1'b1, 4'hF, 1'b0, '0, "R7");
      if (abortSync) begin
        step(1'b0, 4'h0, 1'b1, 4'h0, 1'b0, '0, "R8");
        step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, '0, "R11");
        step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, '0, "R11");
        return;
      end
      step(1'b1, 4'hF, 1'b1, 4'h0,    1'b0, '0, "R8");
      step(1'b1, 4'hF, 1'b1, d[3:0],  1'b0, '0, "R9");
      step(1'b1, 4'hF, 1'b1, d[7:4],  1'b0, '0, "R9");
      step(1'b1, 4'hF, 1'b1, 4'hF,    1'b0, '0, "R10");
      step(1'b1, 4'hF, 1'b0, 4'h0,    1'b0, '0, "R10");
    end else begin
      for (int i = 0; i < 6; i++)
        step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, '0, hit ? "R6" : "R4");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ladOe !== 1'b0 || memRdEn !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: oe=%0b rd=%0b expected oe=0 rd=0", ladOe, memRdEn);
    end
    rstN = 1'b1;
    step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, '0, "R1");

    // plain reads, distinct addresses and bytes
    openNib(4'hD, "R2"); body(1'b1, 4'hA, 28'h1234567, 4'h0, 1'b0);
    openNib(4'hD, "R2"); body(1'b1, 4'hA, 28'hFEDCBA9, 4'h0, 1'b0);

    // wrong opening code
    openNib(4'hC, "R2"); body(1'b0, 4'hA, 28'h0000001, 4'h0, 1'b0);

    // long strobe: last low nibble decides
    openNib(4'hD, "R3"); openNib(4'h2, "R3"); body(1'b0, 4'hA, 28'h0ABCDEF, 4'h0, 1'b0);
    openNib(4'h2, "R3"); openNib(4'hD, "R3"); body(1'b1, 4'hA, 28'h7654321, 4'h0, 1'b0);

    // select mismatch, then a new strap value
    openNib(4'hD, "R4"); body(1'b1, 4'h5, 28'h1111111, 4'h0, 1'b0);
    idStrap = 4'h3;
    openNib(4'hD, "R4"); body(1'b1, 4'h3, 28'h8080808, 4'h0, 1'b0);

    // unsupported size
    openNib(4'hD, "R6"); body(1'b1, 4'h3, 28'h2468ACE, 4'h1, 1'b0);

    // abort during the address, then a fresh transaction
    openNib(4'hD, "R11");
    step(1'b1, 4'h3, 1'b0, 4'h0, 1'b0, '0, "R11");
    step(1'b1, 4'h9, 1'b0, 4'h0, 1'b0, '0, "R11");
    step(1'b1, 4'h9, 1'b0, 4'h0, 1'b0, '0, "R11");
    openNib(4'hD, "R11"); body(1'b1, 4'h3, 28'h0F0F0F0, 4'h0, 1'b0);

    // abort during the sync nibble, then a fresh transaction
    openNib(4'hD, "R11"); body(1'b1, 4'h3, 28'hC3C3C3C, 4'h0, 1'b1);
    openNib(4'hD, "R11"); body(1'b1, 4'h3, 28'h5A5A5A5, 4'h0, 1'b0);

    repeat (3) step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, '0, "R2");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: cycles=200000 expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule